// File: doc/BRIEF.md
# Final-Level Page Descriptor Resolver

This unit finishes a paged address translation once the pointer-table entry for the access is already known. A start strobe hands it a logical address, the pointer entry, the root entry, a page-size choice of 4 KiB or 8 KiB, a write flag and a test-only flag. It first checks the upper-level entries. If they allow the access, it works out where the page entry lives, fetches it through a 32-bit read port and follows any indirect entries. It then returns the physical address or signals a bus error. The address of the last page entry it fetched is kept on an output for later inspection.

The memory side has two channels. The request channel is valid/ready. `mem_req_valid` and `mem_req_addr` stay asserted and unchanged until the cycle in which `mem_req_ready` is high, and only one request is outstanding at a time. The response channel has no back-pressure: the unit samples `mem_rsp_valid` on every cycle while it waits and accepts the first beat it sees. Control inputs and result outputs are plain pins. Results hold their value until the next transaction finishes, and `done` marks that moment with a single-cycle pulse.

Top module: `page_desc_resolver`

## Requirements
- R1: After reset, `phys_addr`, `bus_err` and `last_pe_addr` are zero, and `done` and `mem_req_valid` are low.
- R2: For a 4 KiB page (`large_page`=0), the first fetch address is `ptr_entry` with bits 7:0 cleared, plus `logical_addr[17:12]` times 4.
- R3: For an 8 KiB page (`large_page`=1), the first fetch address is `ptr_entry` with bits 6:0 cleared, plus `logical_addr[17:13]` times 4.
- R4: A page entry whose bits 1:0 are 1 or 3 ends the walk without error. The physical address is the entry with its offset bits cleared (11:0 for 4 KiB, 12:0 for 8 KiB), ORed with the same offset bits of the logical address.
- R5: A page entry whose bits 1:0 are 2 is indirect. The next fetch goes to that entry with bits 1:0 cleared, and this repeats. `last_pe_addr` reports the address of the final fetch.
- R6: At most 4 indirect entries are followed. A fifth indirect entry ends the walk with `bus_err`=1, whether or not the access is test-only.
- R7: A page entry whose bits 1:0 are 0 ends the walk. `bus_err` is 1 unless `test_only` is set, and in both cases `phys_addr` equals the logical address.
- R8: If bit 2 of `root_entry` or of `ptr_entry` is set, a write access without `test_only` ends with `bus_err`=1, issues no fetch and leaves `last_pe_addr` unchanged. Reads and test-only accesses are not affected.
- R9: If bit 1 of `ptr_entry` is clear and `test_only` is low, the access ends with `bus_err`=1 and issues no fetch. With `test_only` set, the walk proceeds as normal.
- R10: Every accepted start produces exactly one single-cycle `done` pulse. When `bus_err` is 1, `phys_addr` equals the logical address.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with an unchanged address. Fetch addresses are always word-aligned.
- R12: A `start` pulse that arrives while a walk is in progress is ignored. The running walk's fetches and its result are unaffected, and no extra walk follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a walk when the unit is idle |
| logical_addr | input | 32 | Logical address to translate |
| ptr_entry | input | 32 | Pointer-table entry (bit 1 valid, bit 2 write protect) |
| root_entry | input | 32 | Root-table entry (bit 2 write protect) |
| large_page | input | 1 | 1 selects 8 KiB pages, 0 selects 4 KiB pages |
| is_write | input | 1 | The access is a write |
| test_only | input | 1 | Probe access: suppresses the invalid-entry and protection errors |
| mem_req_valid | output | 1 | Page-entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Page-entry read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| phys_addr | output | 32 | Translated address, or the logical address on error |
| bus_err | output | 1 | The last walk ended in a bus error |
| done | output | 1 | One-cycle completion pulse |
| last_pe_addr | output | 32 | Address of the last page entry fetched |

## Verification
Walks are run with direct entries of both descriptor codes at both page sizes. This separates the index field and the pointer alignment used for 4 KiB pages from those used for 8 KiB pages. Indirect chains of two hops, of exactly four hops and of five hops show where the hop limit lies. Invalid entries, write protection at either upper level and a cleared pointer-valid bit are each tried with and without test-only. This shows which faults that flag suppresses and which it does not. One walk runs under a stalling request channel while a second start is pulsed. It shows whether addresses are held under back-pressure and whether a start during a walk is ignored.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WAIT  = 2'd2
  } pdr_state_e;

  typedef enum logic [1:0] {
    DT_INVALID  = 2'd0,
    DT_PAGE     = 2'd1,
    DT_INDIRECT = 2'd2,
    DT_PAGE_ALT = 2'd3
  } pdr_dtype_e;

  localparam int VALID_BIT = 1;
  localparam int WPROT_BIT = 2;
endpackage

// File: rtl/pdr_index_gen.sv
module pdr_index_gen #(
  parameter int AW        = 32,
  parameter int IDX_TOP   = 17,
  parameter int SMALL_OFF = 12
) (
  input  logic [AW-1:0] logical,
  input  logic [AW-1:0] pointer,
  input  logic          large_page,
  output logic [AW-1:0] entry_addr
);
  localparam int LARGE_OFF   = SMALL_OFF + 1;
  localparam int SMALL_IDX_W = IDX_TOP - SMALL_OFF + 1;
  localparam int LARGE_IDX_W = IDX_TOP - LARGE_OFF + 1;
  localparam int SMALL_CLR   = SMALL_IDX_W + 2;
  localparam int LARGE_CLR   = LARGE_IDX_W + 2;
  localparam logic [AW-1:0] SMALL_KEEP = {AW{1'b1}} << SMALL_CLR;
  localparam logic [AW-1:0] LARGE_KEEP = {AW{1'b1}} << LARGE_CLR;

  logic [AW-1:0] small_addr, large_addr;

  always_comb begin
    small_addr = (pointer & SMALL_KEEP) + (AW'(logical[IDX_TOP:SMALL_OFF]) << 2);
    large_addr = (pointer & LARGE_KEEP) + (AW'(logical[IDX_TOP:LARGE_OFF]) << 2);
    entry_addr = large_page ? large_addr : small_addr;
  end
endmodule

// File: rtl/pdr_entry_eval.sv
module pdr_entry_eval
  import pdr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SMALL_OFF = 12
) (
  input  logic [AW-1:0] entry,
  input  logic [AW-1:0] logical,
  input  logic          large_page,
  output pdr_dtype_e    dtype,
  output logic [AW-1:0] link_addr,
  output logic [AW-1:0] phys
);
  localparam logic [AW-1:0] SMALL_MASK = (AW'(1) << SMALL_OFF) - AW'(1);
  localparam logic [AW-1:0] LARGE_MASK = (AW'(1) << (SMALL_OFF + 1)) - AW'(1);

  logic [AW-1:0] off_mask;

  always_comb begin
    off_mask  = large_page ? LARGE_MASK : SMALL_MASK;
    dtype     = pdr_dtype_e'(entry[1:0]);
    link_addr = {entry[AW-1:2], 2'b00};
    phys      = (entry & ~off_mask) | (logical & off_mask);
  end
endmodule

// File: rtl/page_desc_resolver.sv
module page_desc_resolver
  import pdr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDX_TOP   = 17,
  parameter int SMALL_OFF = 12,
  parameter int MAX_HOPS  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] logical_addr,
  input  logic [AW-1:0] ptr_entry,
  input  logic [AW-1:0] root_entry,
  input  logic          large_page,
  input  logic          is_write,
  input  logic          test_only,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic [AW-1:0] phys_addr,
  output logic          bus_err,
  output logic          done,
  output logic [AW-1:0] last_pe_addr
);
  localparam int HOP_W = $clog2(MAX_HOPS + 1);

  pdr_state_e    state;
  logic [AW-1:0] lat_logical;
  logic          lat_large;
  logic          lat_test;
  logic [AW-1:0] req_addr;
  logic [HOP_W-1:0] hops;
  logic [AW-1:0] phys_q;
  logic          err_q;
  logic          done_q;
  logic [AW-1:0] last_q;

  logic [AW-1:0] first_addr;
  pdr_dtype_e    rsp_type;
  logic [AW-1:0] rsp_link;
  logic [AW-1:0] rsp_phys;
  logic          wp_fault;
  logic          ptr_fault;
  logic          hop_limit;

  pdr_index_gen #(
    .AW(AW), .IDX_TOP(IDX_TOP), .SMALL_OFF(SMALL_OFF)
  ) u_index (
    .logical    (logical_addr),
    .pointer    (ptr_entry),
    .large_page (large_page),
    .entry_addr (first_addr)
  );

  pdr_entry_eval #(
    .AW(AW), .SMALL_OFF(SMALL_OFF)
  ) u_eval (
    .entry      (mem_rsp_data),
    .logical    (lat_logical),
    .large_page (lat_large),
    .dtype      (rsp_type),
    .link_addr  (rsp_link),
    .phys       (rsp_phys)
  );

  always_comb begin
    wp_fault  = (root_entry[WPROT_BIT] | ptr_entry[WPROT_BIT]) & is_write & ~test_only;
    ptr_fault = ~ptr_entry[VALID_BIT] & ~test_only;
    hop_limit = (hops == HOP_W'(MAX_HOPS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      lat_logical <= '0;
      lat_large   <= 1'b0;
      lat_test    <= 1'b0;
      req_addr    <= '0;
      hops        <= '0;
      phys_q      <= '0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      last_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            lat_logical <= logical_addr;
            lat_large   <= large_page;
            lat_test    <= test_only;
            hops        <= '0;
            if (wp_fault || ptr_fault) begin
              phys_q <= logical_addr;
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              req_addr <= first_addr;
              last_q   <= first_addr;
              state    <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (mem_req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            unique case (rsp_type)
              DT_INDIRECT: begin
                if (hop_limit) begin
                  phys_q <= lat_logical;
                  err_q  <= 1'b1;
                  done_q <= 1'b1;
                  state  <= S_IDLE;
                end else begin
                  hops     <= hops + HOP_W'(1);
                  req_addr <= rsp_link;
                  last_q   <= rsp_link;
                  state    <= S_FETCH;
                end
              end
              DT_INVALID: begin
                phys_q <= lat_logical;
                err_q  <= ~lat_test;
                done_q <= 1'b1;
                state  <= S_IDLE;
              end
              default: begin
                phys_q <= rsp_phys;
                err_q  <= 1'b0;
                done_q <= 1'b1;
                state  <= S_IDLE;
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == S_FETCH);
  assign mem_req_addr  = req_addr;
  assign phys_addr     = phys_q;
  assign bus_err       = err_q;
  assign done          = done_q;
  assign last_pe_addr  = last_q;

  // Request held steady under back-pressure
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_req_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_logical_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && bus_err |-> phys_addr == lat_logical);

  assert_hop_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) && mem_rsp_valid && (rsp_type == DT_INDIRECT) && hop_limit
      |=> done && bus_err);

  assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) && start |=> $stable(lat_logical));
endmodule

// File: tb/page_desc_resolver_test.sv
module page_desc_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] logical_addr = '0, ptr_entry = '0, root_entry = '0;
  logic        large_page = 1'b0, is_write = 1'b0, test_only = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] phys_addr, last_pe_addr;
  logic        bus_err, done;

  always #5 clk = ~clk;

  page_desc_resolver uut (
    .clk(clk), .rst_n(rst_n), .start(start), .logical_addr(logical_addr),
    .ptr_entry(ptr_entry), .root_entry(root_entry), .large_page(large_page),
    .is_write(is_write), .test_only(test_only),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .phys_addr(phys_addr), .bus_err(bus_err),
    .done(done), .last_pe_addr(last_pe_addr)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_fetch [$];
  logic [31:0] exp_phys, exp_last = '0;
  logic        exp_err;
  int          stall_mode = 0;
  int          cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // Behavioural reference: list of expected fetches and final result
  task automatic ref_walk(input logic [31:0] la, ptr, root, input bit big, wr, tst);
    logic [31:0] a, e, mask;
    int hopc;
    exp_fetch.delete();
    if (((root[2] || ptr[2]) && wr && !tst) || (!ptr[1] && !tst)) begin
      exp_err = 1'b1;
      exp_phys = la;
      return;
    end
    mask = big ? 32'h1FFF : 32'h0FFF;
    a = big ? (ptr & ~32'h7F) + (((la >> 13) & 32'h1F) * 4)
            : (ptr & ~32'hFF) + (((la >> 12) & 32'h3F) * 4);
    hopc = 0;
    forever begin
      exp_fetch.push_back(a);
      exp_last = a;
      e = rd(a);
      if (e[1:0] == 2'd2) begin
        if (hopc == 4) begin exp_err = 1'b1; exp_phys = la; return; end
        hopc++;
        a = e & ~32'h3;
      end else if (e[1:0] == 2'd0) begin
        exp_err = !tst; exp_phys = la; return;
      end else begin
        exp_err = 1'b0; exp_phys = (e & ~mask) | (la & mask); return;
      end
    end
  endtask

  // Memory responder and per-clock fetch comparison
  initial begin
    bit pend = 1'b0;
    logic [31:0] pend_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = pend;
      mem_rsp_data  = pend ? rd(pend_addr) : 32'h0;
      pend = 1'b0;
      mem_req_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      if (mem_req_valid && mem_req_ready) begin
        if (exp_fetch.size() == 0)
          check(1'b0, "R12", "unexpected fetch", mem_req_addr, 32'h0);
        else begin
          check(mem_req_addr == exp_fetch[0], "R5", "fetch address", mem_req_addr, exp_fetch[0]);
          void'(exp_fetch.pop_front());
        end
        pend = 1'b1;
        pend_addr = mem_req_addr;
      end
    end
  end

  task automatic run(input string req, input logic [31:0] la, ptr, root,
                     input bit big, wr, tst, input bit busy_poke);
    int n, pulses;
    bit seen;
    ref_walk(la, ptr, root, big, wr, tst);
    @(negedge clk);
    logical_addr = la; ptr_entry = ptr; root_entry = root;
    large_page = big; is_write = wr; test_only = tst; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = done;
    n = 0;
    while (!seen && n < 500) begin
      if (busy_poke && n == 2) begin
        logical_addr = la ^ 32'h0003_F000; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      seen = done;
      n++;
    end
    start = 1'b0;
    check(seen, req, "done seen", 32'(seen), 32'h1);
    check(phys_addr == exp_phys, req, "phys_addr", phys_addr, exp_phys);
    check(bus_err == exp_err, req, "bus_err", 32'(bus_err), 32'(exp_err));
    check(last_pe_addr == exp_last, req, "last_pe_addr", last_pe_addr, exp_last);
    check(exp_fetch.size() == 0, req, "fetches remaining", 32'(exp_fetch.size()), 32'h0);
    pulses = 0;
    repeat (3) begin
      @(negedge clk);
      if (done) pulses++;
    end
    check(pulses == 0, "R10", "extra done pulse", 32'(pulses), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // direct entries
    mem[32'h0001_23D4] = 32'hABCD_E001;
    mem[32'h0004_009C] = 32'h0055_6003;
    // two-hop chain
    mem[32'h0002_0004] = 32'h0003_0006;
    mem[32'h0003_0004] = 32'h0003_000A;
    mem[32'h0003_0008] = 32'h7777_7001;
    // four-hop chain
    mem[32'h0005_0000] = 32'h0005_0012;
    mem[32'h0005_0010] = 32'h0005_0022;
    mem[32'h0005_0020] = 32'h0005_0032;
    mem[32'h0005_0030] = 32'h0005_0042;
    mem[32'h0005_0040] = 32'h8888_0001;
    // five-hop chain
    mem[32'h0006_0000] = 32'h0006_0012;
    mem[32'h0006_0010] = 32'h0006_0022;
    mem[32'h0006_0020] = 32'h0006_0032;
    mem[32'h0006_0030] = 32'h0006_0042;
    mem[32'h0006_0040] = 32'h0006_0052;

    repeat (3) @(negedge clk);
    check(phys_addr == 0 && last_pe_addr == 0, "R1", "reset addresses", phys_addr | last_pe_addr, 32'h0);
    check(!bus_err && !done && !mem_req_valid, "R1", "reset flags",
          {29'h0, bus_err, done, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R2", 32'h0003_5ABC, 32'h0001_2302, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R3", 32'h1234_E456, 32'h0004_00FE, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R4", 32'h1234_E456, 32'h0004_00FE, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0);
    stall_mode = 1;
    run("R11", 32'h0000_1234, 32'h0002_0002, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R12", 32'h0000_1FFF, 32'h0002_0002, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1);
    stall_mode = 0;
    run("R5", 32'h0000_1010, 32'h0002_0002, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R6", 32'h0000_0ABC, 32'h0005_0002, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R6", 32'h0000_0ABC, 32'h0006_0002, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R6", 32'h0000_0ABC, 32'h0006_0002, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R7", 32'h0000_5008, 32'h0007_0002, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R7", 32'h0000_5008, 32'h0007_0002, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R8", 32'h0003_5ABC, 32'h0001_2302, 32'h4, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R8", 32'h0003_5ABC, 32'h0001_2306, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R8", 32'h0003_5ABC, 32'h0001_2306, 32'h4, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R8", 32'h0003_5ABC, 32'h0001_2306, 32'h4, 1'b0, 1'b1, 1'b1, 1'b0);
    run("R9", 32'h0003_5ABC, 32'h0001_2300, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R10", 32'h0003_5ABC, 32'h0001_2300, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule